// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block lets an external controller reach a bank of 128 eight-bit registers over one shared data line. The line is modelled as separate input, output and output-enable signals. A second active-low select opens a byte path into two on-chip FIFOs. Serial bytes shifted in go to a transmit FIFO that the core drains. Bytes that the core pushes into a receive FIFO are shifted back out to the controller.

Every serial input is synchronised into the system clock domain. Serial-clock edges are found by comparing the synchronised clock with its value in the previous cycle. A register frame starts with a read/write flag, followed by a 7-bit address and one data byte. For a read, the block turns the data line around at one fixed point in the frame. If both selects are seen active together, the block raises a protocol error and takes no part in the transfer.

Top module: `spi3w_reg_slave`

## Requirements
- R1: A register frame sends a flag bit first (1 = read, 0 = write), then a 7-bit address and then one data byte. The address and the data are both sent most significant bit first.
- R2: The block samples the data line on the rising edge of the serial clock. It changes its own output only on the falling edge, so the driven bit stays stable through the whole high phase that follows.
- R3: A write stores the byte into the addressed register on the rising edge that carries data bit 0. A later read of that address returns the byte.
- R4: During a read, the output enable stays low for all eight flag and address bits. This includes the high phase after the last address bit. The enable rises on the next falling edge, and data bit 7 is driven from that edge.
- R5: Raising the register select before the frame ends abandons the frame. The output enable is released and the partly received byte is not stored.
- R6: While both selects are active, proto_err is 1 and the output enable is 0, and no register changes. proto_err returns to 0 once both selects are high.
- R7: After reset, every register reads 0x00, the output enable is 0, both flags are 0 and both FIFOs are empty.
- R8: Bit 0 of register 0x7F sets the FIFO direction. When it is 0, each group of 8 bits shifted in under the FIFO select (MSB first) is pushed into the 32-entry transmit FIFO. The core sees the head byte on tx_data and removes it with tx_pop, in arrival order.
- R9: A byte that arrives while the transmit FIFO holds 32 entries is dropped, and fifo_ovf is set and held until reset.
- R10: When bit 0 of register 0x7F is 1, the FIFO select drives the oldest receive-FIFO byte MSB first, starting as soon as the select is taken. Each byte leaves the FIFO after its eighth rising edge. rx_full is 1 when the receive FIFO holds 32 entries.
- R11: Reading a byte from an empty receive FIFO returns 0x00 and sets fifo_udf, which is held until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| reg_cs_n | input | 1 | Active-low register select |
| fifo_cs_n | input | 1 | Active-low FIFO select |
| sdi | input | 1 | Data line as seen by the block |
| sdo | output | 1 | Data the block drives onto the line |
| sdo_oe | output | 1 | Output enable for the data line driver |
| proto_err | output | 1 | Both selects seen active together |
| tx_pop | input | 1 | Core removes the transmit FIFO head |
| tx_data | output | 8 | Transmit FIFO head byte |
| tx_empty | output | 1 | Transmit FIFO holds no bytes |
| rx_push | input | 1 | Core appends rx_wdata to the receive FIFO |
| rx_wdata | input | 8 | Byte for the receive FIFO |
| rx_full | output | 1 | Receive FIFO holds 32 bytes |
| fifo_ovf | output | 1 | Sticky: byte dropped at a full transmit FIFO |
| fifo_udf | output | 1 | Sticky: byte read from an empty receive FIFO |

## Verification
A bit counter that is off by one moves the address by one bit. That error shows in the first readback of the register sweep, because every register holds a distinct byte. A turnaround that comes too early shows as the output enable being high in the high phase of the last address bit, within the same frame. A FIFO pointer or count error shows as a byte out of order, or as a full or empty flag on the wrong byte, by the 33rd byte of a session at the latest.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

   typedef enum logic [1:0] {
      SEL_IDLE     = 2'd0,
      SEL_REG      = 2'd1,
      SEL_FIFO     = 2'd2,
      SEL_CONFLICT = 2'd3
   } sel_e;

   function automatic sel_e decode_sel(input logic reg_act, input logic fifo_act);
      if (reg_act && fifo_act) return SEL_CONFLICT;
      if (reg_act)             return SEL_REG;
      if (fifo_act)            return SEL_FIFO;
      return SEL_IDLE;
   endfunction

endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
   parameter int unsigned             WIDTH   = 4,
   parameter int unsigned             STAGES  = 2,
   parameter logic [WIDTH-1:0]        RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("spi3w_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi3w_byte_fifo.sv
module spi3w_byte_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi3w_byte_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi3w_byte_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_MAX);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);

   // R9
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_MAX);

   // R11
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);

endmodule

// File: rtl/spi3w_regbank.sv
module spi3w_regbank #(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CTL_ADDR = 127,
   parameter int unsigned CTL_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              ctl_bit
);

   localparam int unsigned NREG = 1 << ADDR_W;

   if (CTL_ADDR >= NREG) begin : g_bad_ctl_addr
      $error("spi3w_regbank: CTL_ADDR outside the bank");
   end
   if (CTL_BIT >= DATA_W) begin : g_bad_ctl_bit
      $error("spi3w_regbank: CTL_BIT outside the register");
   end

   logic [DATA_W-1:0] regs [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   assign rdata   = regs[raddr];
   assign ctl_bit = regs[CTL_ADDR][CTL_BIT];

   // R3
   write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/spi3w_reg_slave.sv
module spi3w_reg_slave
   import spi3w_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned FIFO_DEPTH  = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CTL_ADDR    = 127,
   parameter int unsigned CTL_BIT     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              reg_cs_n,
   input  logic              fifo_cs_n,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              proto_err,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_empty,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_wdata,
   output logic              rx_full,
   output logic              fifo_ovf,
   output logic              fifo_udf
);

   localparam int unsigned HEAD  = 1 + ADDR_W;
   localparam int unsigned FRAME = HEAD + DATA_W;
   localparam int unsigned CNT_W = $clog2(FRAME + 1);
   localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] CNT_HEAD      = CNT_W'(HEAD);
   localparam logic [CNT_W-1:0] CNT_WR_LAST   = CNT_W'(FRAME - 1);
   localparam logic [CNT_W-1:0] CNT_FRAME     = CNT_W'(FRAME);
   localparam logic [CNT_W-1:0] CNT_BYTE_LAST = CNT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("spi3w_reg_slave: DATA_W must be at least 2");
   end
   if (ADDR_W < 2 || ADDR_W > DATA_W + 1) begin : g_bad_addr_w
      $error("spi3w_reg_slave: ADDR_W must lie in 2..DATA_W+1");
   end

   // ---------------- input synchronisation ----------------
   logic [3:0] sync_q;
   logic       sclk_s, rcs_s, fcs_s, sdi_s, sclk_p;

   spi3w_sync #(
      .WIDTH  (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b0110)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in ({sclk, reg_cs_n, fifo_cs_n, sdi}),
      .q    (sync_q)
   );

   assign {sclk_s, rcs_s, fcs_s, sdi_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_p <= 1'b0;
      else        sclk_p <= sclk_s;
   end

   logic rise, fall;
   assign rise = sclk_s && !sclk_p;
   assign fall = !sclk_s && sclk_p;

   // ---------------- select decode ----------------
   sel_e sel, sel_q;
   logic err_q, fresh, reg_mode, fifo_mode;

   assign sel       = decode_sel(!rcs_s, !fcs_s);
   assign fresh     = (sel != sel_q);
   assign reg_mode  = (sel == SEL_REG)  && !err_q;
   assign fifo_mode = (sel == SEL_FIFO) && !err_q;

   // ---------------- frame state ----------------
   logic [CNT_W-1:0]  cnt_q;
   logic              rw_q, oe_q, ovf_q, udf_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] sh_in_q, sh_out_q, rx_byte, reg_rdata, rx_head;
   logic [DATA_W-1:0] rx_word;
   logic              fifo_dir, reg_we, tx_push, tx_full, rx_pop, rx_empty;

   assign rx_word = {sh_in_q[DATA_W-2:0], sdi_s};
   assign reg_we  = reg_mode && !fresh && rise && !rw_q && (cnt_q == CNT_WR_LAST);
   assign tx_push = fifo_mode && !fresh && rise && !fifo_dir && (cnt_q == CNT_BYTE_LAST);
   assign rx_pop  = fifo_mode && !fresh && rise &&  fifo_dir && (cnt_q == CNT_BYTE_LAST);
   assign rx_byte = rx_empty ? '0 : rx_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= SEL_IDLE;
         err_q    <= 1'b0;
         cnt_q    <= '0;
         rw_q     <= 1'b0;
         addr_q   <= '0;
         sh_in_q  <= '0;
         sh_out_q <= '0;
         oe_q     <= 1'b0;
         ovf_q    <= 1'b0;
         udf_q    <= 1'b0;
      end else begin
         sel_q <= sel;
         if (sel == SEL_CONFLICT)  err_q <= 1'b1;
         else if (sel == SEL_IDLE) err_q <= 1'b0;
         if (tx_push && tx_full)   ovf_q <= 1'b1;
         if (rx_pop && rx_empty)   udf_q <= 1'b1;

         if (reg_mode) begin
            if (fresh) begin
               cnt_q <= '0;
               oe_q  <= 1'b0;
            end else begin
               if (rise && cnt_q != CNT_FRAME) begin
                  sh_in_q <= rx_word;
                  cnt_q   <= cnt_q + 1'b1;
                  if (cnt_q == '0)           rw_q   <= sdi_s;
                  if (cnt_q == CNT_ADDR_LAST) addr_q <= {sh_in_q[ADDR_W-2:0], sdi_s};
               end
               if (fall && rw_q && cnt_q == CNT_HEAD) begin
                  oe_q     <= 1'b1;
                  sh_out_q <= reg_rdata;
               end else if (fall && oe_q) begin
                  sh_out_q <= {sh_out_q[DATA_W-2:0], 1'b0};
               end
            end
         end else if (fifo_mode) begin
            if (fresh) begin
               cnt_q    <= '0;
               oe_q     <= fifo_dir;
               sh_out_q <= rx_byte;
            end else begin
               if (rise) begin
                  sh_in_q <= rx_word;
                  cnt_q   <= (cnt_q == CNT_BYTE_LAST) ? '0 : cnt_q + 1'b1;
               end
               if (fall && fifo_dir) begin
                  sh_out_q <= (cnt_q == '0) ? rx_byte : {sh_out_q[DATA_W-2:0], 1'b0};
               end
            end
         end else begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
         end
      end
   end

   // ---------------- storage ----------------
   spi3w_regbank #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CTL_ADDR(CTL_ADDR),
      .CTL_BIT (CTL_BIT)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .waddr  (addr_q),
      .wdata  (rx_word),
      .raddr  (addr_q),
      .rdata  (reg_rdata),
      .ctl_bit(fifo_dir)
   );

   spi3w_byte_fifo #(
      .WIDTH(DATA_W),
      .DEPTH(FIFO_DEPTH)
   ) u_tx_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (tx_push),
      .wdata(rx_word),
      .pop  (tx_pop),
      .head (tx_data),
      .empty(tx_empty),
      .full (tx_full)
   );

   spi3w_byte_fifo #(
      .WIDTH(DATA_W),
      .DEPTH(FIFO_DEPTH)
   ) u_rx_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (rx_push),
      .wdata(rx_wdata),
      .pop  (rx_pop),
      .head (rx_head),
      .empty(rx_empty),
      .full (rx_full)
   );

   assign sdo       = sh_out_q[DATA_W-1];
   assign sdo_oe    = oe_q;
   assign proto_err = err_q;
   assign fifo_ovf  = ovf_q;
   assign fifo_udf  = udf_q;

   // R6
   conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !oe_q);

   // R4
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && sel_q == SEL_REG) |-> (rw_q && cnt_q >= CNT_HEAD));

   // R5
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcs_s && fcs_s) |=> !oe_q);

endmodule

// File: tb/spi3w_reg_slave_bench.sv
module spi3w_reg_slave_bench;

   localparam int H = 6;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sclk = 1'b0, reg_cs_n = 1'b1, fifo_cs_n = 1'b1, sdi = 1'b0;
   logic       tx_pop = 1'b0, rx_push = 1'b0;
   logic [7:0] rx_wdata = 8'h00;
   logic       sdo, sdo_oe, proto_err, tx_empty, rx_full, fifo_ovf, fifo_udf;
   logic [7:0] tx_data;
   int         n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   spi3w_reg_slave u_spi3w_reg_slave (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .reg_cs_n(reg_cs_n),
      .fifo_cs_n(fifo_cs_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
      .proto_err(proto_err), .tx_pop(tx_pop), .tx_data(tx_data),
      .tx_empty(tx_empty), .rx_push(rx_push), .rx_wdata(rx_wdata),
      .rx_full(rx_full), .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 73 + 29) & 255);
   endfunction
   function automatic logic [7:0] tpat(input int k);
      return 8'((k * 29 + 7) & 255);
   endfunction
   function automatic logic [7:0] rpat(input int k);
      return 8'((k * 53 + 11) & 255);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_xfer(input logic b, output logic got, output logic got_hi,
                           output logic oe_lo, output logic oe_hi);
      sdi = b;
      tick(H);
      got   = sdo;
      oe_lo = sdo_oe;
      sclk  = 1'b1;
      tick(H);
      got_hi = sdo;
      oe_hi  = sdo_oe;
      sclk   = 1'b0;
   endtask

   task automatic reg_xfer(input logic rd, input logic [6:0] a, input logic [7:0] wd,
                           input int nbits, output logic [7:0] got_byte,
                           output int oe_faults, output int hold_faults);
      logic b, g, gh, lo, hi;
      oe_faults   = 0;
      hold_faults = 0;
      got_byte    = 8'h00;
      reg_cs_n    = 1'b0;
      tick(H);
      for (int i = 0; i < nbits; i++) begin
         if (i == 0)     b = rd;
         else if (i < 8) b = a[7-i];
         else            b = wd[15-i];
         bit_xfer(b, g, gh, lo, hi);
         if (i < 8 || !rd) begin
            if (lo || hi) oe_faults++;
         end else begin
            if (!lo || !hi) oe_faults++;
            if (g != gh) hold_faults++;
            got_byte[15-i] = g;
         end
      end
      tick(H);
      reg_cs_n = 1'b1;
      tick(4 * H);
   endtask

   task automatic fifo_send(input logic [7:0] v);
      logic g, gh, lo, hi;
      for (int i = 0; i < 8; i++) bit_xfer(v[7-i], g, gh, lo, hi);
   endtask

   task automatic fifo_recv(output logic [7:0] v, output int oe_faults);
      logic g, gh, lo, hi;
      oe_faults = 0;
      v = 8'h00;
      for (int i = 0; i < 8; i++) begin
         bit_xfer(1'b0, g, gh, lo, hi);
         if (!lo || !hi) oe_faults++;
         v[7-i] = g;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0] rb;
      int         oef, hf, oe_tot, hf_tot, bad;

      tick(5);
      rst_n = 1'b1;
      tick(4);

      // R7 reset state at the ports
      chk("R7", "sdo_oe after reset", int'(sdo_oe), 0);
      chk("R7", "proto_err after reset", int'(proto_err), 0);
      chk("R7", "tx_empty after reset", int'(tx_empty), 1);
      chk("R7", "rx_full after reset", int'(rx_full), 0);
      chk("R7", "fifo_ovf after reset", int'(fifo_ovf), 0);
      chk("R7", "fifo_udf after reset", int'(fifo_udf), 0);
      bad = 0;
      for (int a = 0; a < 128; a += 9) begin
         reg_xfer(1'b1, 7'(a), 8'h00, 16, rb, oef, hf);
         if (rb != 8'h00) bad++;
      end
      chk("R7", "registers nonzero after reset", bad, 0);

      // R1 R3: write every register with a distinct byte
      oe_tot = 0;
      for (int a = 0; a < 128; a++) begin
         reg_xfer(1'b0, 7'(a), pat(a), 16, rb, oef, hf);
         oe_tot += oef;
      end
      chk("R4", "driver enabled during write frames", oe_tot, 0);

      // R1 R2 R3 R4: read every register back
      oe_tot = 0;
      hf_tot = 0;
      for (int a = 0; a < 128; a++) begin
         reg_xfer(1'b1, 7'(a), 8'h00, 16, rb, oef, hf);
         chk("R3", $sformatf("readback addr %0d", a), int'(rb), int'(pat(a)));
         oe_tot += oef;
         hf_tot += hf;
      end
      chk("R4", "turnaround faults over read sweep", oe_tot, 0);
      chk("R2", "bit changed during high phase", hf_tot, 0);

      // R5: partial write leaves register unchanged
      reg_xfer(1'b0, 7'd5, 8'hA5, 12, rb, oef, hf);
      reg_xfer(1'b1, 7'd5, 8'h00, 16, rb, oef, hf);
      chk("R5", "partial write reg 5", int'(rb), int'(pat(5)));
      // R5: aborted read releases the driver
      reg_xfer(1'b1, 7'd3, 8'h00, 12, rb, oef, hf);
      chk("R5", "driver released after abort", int'(sdo_oe), 0);
      chk("R5", "aborted read partial bits", int'(rb[7:4]), int'(pat(3) >> 4));

      // R6: both selects active
      fifo_cs_n = 1'b0;
      tick(4 * H);
      reg_cs_n = 1'b0;
      tick(4 * H);
      chk("R6", "proto_err while both low", int'(proto_err), 1);
      reg_cs_n = 1'b1;
      tick(H);
      reg_xfer(1'b0, 7'd9, 8'h3C, 16, rb, oef, hf);
      chk("R6", "driver enabled during conflict", oef, 0);
      chk("R6", "proto_err held until idle", int'(proto_err), 1);
      fifo_cs_n = 1'b1;
      tick(4 * H);
      chk("R6", "proto_err after idle", int'(proto_err), 0);
      reg_xfer(1'b1, 7'd9, 8'h00, 16, rb, oef, hf);
      chk("R6", "reg 9 untouched by conflict write", int'(rb), int'(pat(9)));

      // R8 R9: transmit FIFO (register 0x7F bit 0 is 0 from the sweep)
      fifo_cs_n = 1'b0;
      tick(H);
      for (int k = 0; k < 32; k++) fifo_send(tpat(k));
      tick(H);
      fifo_cs_n = 1'b1;
      tick(4 * H);
      chk("R8", "tx_empty after 32 bytes", int'(tx_empty), 0);
      chk("R9", "fifo_ovf before overflow", int'(fifo_ovf), 0);
      fifo_cs_n = 1'b0;
      tick(H);
      fifo_send(8'hEE);
      tick(H);
      fifo_cs_n = 1'b1;
      tick(4 * H);
      chk("R9", "fifo_ovf after 33rd byte", int'(fifo_ovf), 1);
      bad = 0;
      for (int k = 0; k < 32; k++) begin
         if (tx_data != tpat(k)) begin
            bad++;
            $display("FAIL R8 tx byte %0d: actual %0h expected %0h", k, tx_data, tpat(k));
         end
         tx_pop = 1'b1;
         tick(1);
         tx_pop = 1'b0;
      end
      chk("R8", "tx bytes out of order", bad, 0);
      chk("R9", "tx_empty after draining (extra byte dropped)", int'(tx_empty), 1);

      // R10 R11: receive FIFO
      reg_xfer(1'b0, 7'h7F, 8'h01, 16, rb, oef, hf);
      for (int k = 0; k < 32; k++) begin
         rx_wdata = rpat(k);
         rx_push  = 1'b1;
         tick(1);
         rx_push  = 1'b0;
      end
      tick(1);
      chk("R10", "rx_full after 32 pushes", int'(rx_full), 1);
      fifo_cs_n = 1'b0;
      tick(H);
      oe_tot = 0;
      for (int k = 0; k < 32; k++) begin
         fifo_recv(rb, oef);
         oe_tot += oef;
         chk("R10", $sformatf("rx byte %0d", k), int'(rb), int'(rpat(k)));
      end
      chk("R10", "driver off during fifo read", oe_tot, 0);
      chk("R11", "fifo_udf before empty read", int'(fifo_udf), 0);
      fifo_recv(rb, oef);
      chk("R11", "empty read value", int'(rb), 0);
      tick(H);
      fifo_cs_n = 1'b1;
      tick(4 * H);
      chk("R11", "fifo_udf after empty read", int'(fifo_udf), 1);
      chk("R10", "rx_full after draining", int'(rx_full), 0);
      chk("R5", "driver released after fifo session", int'(sdo_oe), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule